// File: doc/BRIEF.md
# Phase-Frequency Detector with Decimal Divide-by-1000 Feedback

This block is the digital core of a frequency multiplier that multiplies by one thousand. The oscillator clock drives a chain of three decimal counter stages. Each stage counts 0 to 9 and passes a carry to the next. The last stage produces a divided feedback waveform whose period is 1000 oscillator cycles. A phase-frequency detector compares the falling edges of this feedback signal with the falling edges of the reference input. It drives two active-low correction outputs, one meaning "oscillator too slow" and one meaning "oscillator too fast". An external charge pump and loop filter turn these outputs into the oscillator control voltage.

The whole block is clocked by the oscillator clock. The reference input is assumed to be synchronous to that clock, so its level is taken at each rising clock edge. A falling edge on either detector input is seen at the first rising clock edge where the level is low after having been high. Rising edges on either input have no effect. When the two falling edges arrive in the same cycle, the loop is in lock and both outputs stay high.

Top module: `pll_pfd_div1000`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears both detector states and all counter stages. After that edge `up_n` and `down_n` are 1 and `fb_div` is 0.
- R2: Count edges from the first rising edge with `rst_n` high as edge 1. `fb_div` goes to 1 after edge 500 and returns to 0 after edge 1000. The pattern repeats every 1000 edges.
- R3: Each counter stage wraps from 9 to 0 on the edge where its enable and its count of 9 meet, and that carry enables the next stage. `fb_div` falls on the edge where the third stage wraps.
- R4: Suppose neither state is set and the first rising edge at which `ref_in` is seen low (after being high) does not also see a feedback falling edge. Then `up_n` goes to 0 after that edge. It stays 0 until the edge that sees the next falling edge of `fb_div`.
- R5: Suppose neither state is set and the first rising edge after `fb_div` has fallen does not also see a reference falling edge. Then `down_n` goes to 0 after that edge. It stays 0 until the edge that sees the next falling edge of `ref_in`.
- R6: When the pending state is set and the opposite input's falling edge arrives, both states clear on that edge, and `up_n` and `down_n` are both 1 after it.
- R7: When a reference falling edge and a feedback falling edge are seen at the same clock edge, neither `up_n` nor `down_n` goes to 0.
- R8: A rising edge on `ref_in` or on `fb_div` changes neither `up_n` nor `down_n`.
- R9: `up_n` and `down_n` are never 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock; clocks all logic |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_in | input | 1 | Reference signal; falling edges are compared |
| fb_div | output | 1 | Oscillator divided by 1000; falls when the last stage wraps |
| up_n | output | 1 | Active low: reference edge came first, raise the frequency |
| down_n | output | 1 | Active low: feedback edge came first, lower the frequency |

## Verification
The divided output changes after the clock edge that updates the last counter stage. The bench therefore expects `fb_div` high right after edge 500 and low right after edge 1000, counted from reset release. A falling edge on either detector input is registered one stage before the correction state. As a result, a reference level driven low after edge k shows on `up_n` only after edge k+1. A feedback fall that appears after edge 1000 shows on `down_n` after edge 1001. Each task drives inputs on falling clock edges and samples outputs on the falling edge that follows the edge counted above. It also checks the cycle before each transition, so that a change that comes one cycle early or late is caught.

// File: rtl/pfd_div_pkg.sv
// Package: shared constants for the divide-by-1000 phase-frequency detector.
// Assumes decimal counter stages; the modulus and stage count are defaults
// that the modules can override.
package pfd_div_pkg;
    parameter int STAGE_MOD = 10;   // counts per divider stage
    parameter int NUM_STAGES = 3;   // cascaded stages, 10^3 = 1000

    // Detector state kept as a packed pair
    typedef struct packed {
        logic lead_ref;   // reference edge pending its feedback partner
        logic lead_fb;    // feedback edge pending its reference partner
    } pfd_state_t;
endpackage

// File: rtl/decade_stage.sv
// Module: decade_stage
// One counter stage of the feedback divider. Counts 0..MOD-1 while enabled
// and raises a combinational carry in the cycle it holds MOD-1 with enable
// high, so the next stage advances on the same edge that this one wraps.
// Assumes a synchronous active-low reset.
module decade_stage #(
    parameter int MOD = pfd_div_pkg::STAGE_MOD,
    localparam int W = $clog2(MOD)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] digit,
    output logic         carry
);
    localparam logic [W-1:0] LAST = W'(MOD - 1);

    logic [W-1:0] cnt_q;

    // Carry when enabled at the terminal count
    always_comb carry = en && (cnt_q == LAST);

    // Count up, wrap at the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (carry)
            cnt_q <= '0;
        else if (en)
            cnt_q <= cnt_q + 1'b1;
    end

    assign digit = cnt_q;

    // R3: the stage never leaves its range
    p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R3: after a carry the stage is back at zero
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> (cnt_q == '0));

    // R3: without enable the count holds
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt_q));
endmodule

// File: rtl/feedback_divider.sv
// Module: feedback_divider
// Cascades STAGES counter stages to divide the oscillator clock by MOD^STAGES.
// The output is high while the last stage is in its upper half and falls on
// the edge where the last stage wraps, which is the feedback event.
// Assumes MOD is even so the output has an equal duty cycle.
module feedback_divider #(
    parameter int MOD    = pfd_div_pkg::STAGE_MOD,
    parameter int STAGES = pfd_div_pkg::NUM_STAGES,
    localparam int W = $clog2(MOD)
) (
    input  logic clk,
    input  logic rst_n,
    output logic div_out
);
    localparam logic [W-1:0] HALF = W'(MOD / 2);

    logic [STAGES:0] en_chain;
    logic [W-1:0]    digit [STAGES];

    assign en_chain[0] = 1'b1;

    // One stage per decimal digit, each enabled by the previous carry
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        decade_stage #(.MOD(MOD)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_chain[i]),
            .digit (digit[i]),
            .carry (en_chain[i+1])
        );

        // R3: every digit stays inside its range
        p_digit_r3: assert property (@(posedge clk) disable iff (!rst_n)
            digit[i] < W'(MOD));
    end

    // Output level from the most significant digit
    always_comb div_out = (digit[STAGES-1] >= HALF);

    // R3: the last carry is the feedback falling edge
    p_fb_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_chain[STAGES] |=> !div_out);

    // R2: the output only falls on the last carry
    p_fall_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (div_out && !en_chain[STAGES]) |=> div_out);
endmodule

// File: rtl/phase_freq_detector.sv
// Module: phase_freq_detector
// Edge-ordered phase-frequency detector on falling edges of two inputs that
// are synchronous to clk. A lone reference edge sets the lead_ref state, a
// lone feedback edge sets lead_fb, and once both are set they clear together.
// Outputs are active low. Rising input edges are ignored.
module phase_freq_detector
    import pfd_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_lvl,
    input  logic fb_lvl,
    output logic up_n,
    output logic down_n
);
    logic       ref_prev, fb_prev;
    logic       ref_fall, fb_fall;
    pfd_state_t st_q, st_set;

    // Falling edge detection against the previous level
    always_comb begin
        ref_fall = ref_prev && !ref_lvl;
        fb_fall  = fb_prev  && !fb_lvl;
    end

    // Remember input levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_prev <= 1'b0;
            fb_prev  <= 1'b0;
        end else begin
            ref_prev <= ref_lvl;
            fb_prev  <= fb_lvl;
        end
    end

    // States after this edge's events, before the mutual clear
    always_comb begin
        st_set.lead_ref = st_q.lead_ref || ref_fall;
        st_set.lead_fb  = st_q.lead_fb  || fb_fall;
    end

    // Update the detector state; both set means clear both
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else if (st_set.lead_ref && st_set.lead_fb)
            st_q <= '0;
        else
            st_q <= st_set;
    end

    assign up_n   = !st_q.lead_ref;
    assign down_n = !st_q.lead_fb;

    // R9: never both corrections at once
    p_not_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.lead_ref && st_q.lead_fb));

    // R4: a lone reference edge raises the speed-up request
    p_ref_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_fall && !fb_fall && !st_q.lead_fb) |=> !up_n);

    // R4: the speed-up request holds until a feedback edge
    p_up_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_n && !fb_fall) |=> !up_n);

    // R5: a lone feedback edge raises the slow-down request
    p_fb_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_fall && !ref_fall && !st_q.lead_ref) |=> !down_n);

    // R6: the partner edge clears both requests
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((!up_n && fb_fall) || (!down_n && ref_fall)) |=> (up_n && down_n));

    // R7: coincident edges leave both outputs high
    p_coincide_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_fall && fb_fall && up_n && down_n) |=> (up_n && down_n));

    // R8: no falling edge, idle state stays idle
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_fall && !fb_fall && up_n && down_n) |=> (up_n && down_n));
endmodule

// File: rtl/pll_pfd_div1000.sv
// Module: pll_pfd_div1000
// Digital core of a multiply-by-1000 loop: the oscillator clock is divided
// by three cascaded decimal stages, and the divided signal is compared with
// the reference by a falling-edge phase-frequency detector. Assumes ref_in is
// synchronous to clk_osc; the analog loop parts are outside this block.
module pll_pfd_div1000 #(
    parameter int MOD    = pfd_div_pkg::STAGE_MOD,
    parameter int STAGES = pfd_div_pkg::NUM_STAGES
) (
    input  logic clk_osc,
    input  logic rst_n,
    input  logic ref_in,
    output logic fb_div,
    output logic up_n,
    output logic down_n
);
    logic fb_int;

    feedback_divider #(.MOD(MOD), .STAGES(STAGES)) u_div (
        .clk     (clk_osc),
        .rst_n   (rst_n),
        .div_out (fb_int)
    );

    phase_freq_detector u_pfd (
        .clk    (clk_osc),
        .rst_n  (rst_n),
        .ref_lvl(ref_in),
        .fb_lvl (fb_int),
        .up_n   (up_n),
        .down_n (down_n)
    );

    assign fb_div = fb_int;

    // R1: the first edge after a reset edge shows idle outputs
    p_reset_r1: assert property (@(posedge clk_osc)
        !rst_n |=> (up_n && down_n && !fb_div));
endmodule

// File: tb/pll_pfd_div1000_tb.sv
module pll_pfd_div1000_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b1;
    logic fb_div, up_n, down_n;
    int   checks = 0;
    int   errors = 0;
    int   now = 0;   // rising edges since reset release

    always #5 clk = ~clk;   // 100 MHz

    pll_pfd_div1000 u_dut (
        .clk_osc(clk), .rst_n(rst_n), .ref_in(ref_in),
        .fb_div(fb_div), .up_n(up_n), .down_n(down_n)
    );

    task automatic check(input string req, input logic act, input logic exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at edge %0d: actual=%b expected=%b",
                     req, what, now, act, exp);
        end
    endtask

    // Reset with a chosen reference level; ends on the negedge of release
    task automatic do_reset(input logic ref_lvl);
        @(negedge clk);
        rst_n  = 1'b0;
        ref_in = ref_lvl;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        now = 0;
    endtask

    // Advance to the negedge following rising edge k
    task automatic go_to(input int k);
        while (now < k) begin
            @(posedge clk);
            now++;
        end
        @(negedge clk);
    endtask

    task automatic t_reset;
        do_reset(1'b1);
        check("R1", up_n, 1'b1, "up_n after reset");
        check("R1", down_n, 1'b1, "down_n after reset");
        check("R1", fb_div, 1'b0, "fb_div after reset");
    endtask

    task automatic t_divider;
        do_reset(1'b1);
        // Hold reference still: the chain alone sets the period
        go_to(499);  check("R2", fb_div, 1'b0, "fb_div before half");
        go_to(500);  check("R2", fb_div, 1'b1, "fb_div at half");
        go_to(999);  check("R3", fb_div, 1'b1, "fb_div before wrap");
        go_to(1000); check("R3", fb_div, 1'b0, "fb_div at wrap");
        go_to(1500); check("R2", fb_div, 1'b1, "fb_div second half");
        go_to(2000); check("R2", fb_div, 1'b0, "fb_div second wrap");
    endtask

    task automatic t_fb_leads;
        do_reset(1'b1);
        go_to(1000); check("R5", down_n, 1'b1, "down_n before edge seen");
        go_to(1001); check("R5", down_n, 1'b0, "down_n after fb fall");
        check("R9", up_n, 1'b1, "up_n while down_n low");
        go_to(1200); check("R5", down_n, 1'b0, "down_n held");
        ref_in = 1'b0;
        go_to(1201);
        check("R6", down_n, 1'b1, "down_n cleared by ref");
        check("R6", up_n, 1'b1, "up_n after clear");
    endtask

    task automatic t_ref_leads;
        do_reset(1'b1);
        go_to(300);
        ref_in = 1'b0;
        check("R4", up_n, 1'b1, "up_n before edge seen");
        go_to(301);  check("R4", up_n, 1'b0, "up_n after ref fall");
        check("R9", down_n, 1'b1, "down_n while up_n low");
        go_to(1000); check("R4", up_n, 1'b0, "up_n held to fb");
        go_to(1001);
        check("R6", up_n, 1'b1, "up_n cleared by fb");
        check("R6", down_n, 1'b1, "down_n after clear");
    endtask

    task automatic t_locked;
        do_reset(1'b1);
        go_to(1000);
        ref_in = 1'b0;
        go_to(1001);
        check("R7", up_n, 1'b1, "up_n coincident");
        check("R7", down_n, 1'b1, "down_n coincident");
        go_to(1002);
        check("R7", up_n, 1'b1, "up_n after coincident");
        check("R7", down_n, 1'b1, "down_n after coincident");
        go_to(1500);
        ref_in = 1'b1;
        go_to(2000);
        ref_in = 1'b0;
        go_to(2001);
        check("R7", up_n, 1'b1, "up_n second lock");
        check("R7", down_n, 1'b1, "down_n second lock");
    endtask

    task automatic t_rising;
        do_reset(1'b0);
        go_to(100);
        ref_in = 1'b1;
        go_to(101);
        check("R8", up_n, 1'b1, "up_n after ref rise");
        check("R8", down_n, 1'b1, "down_n after ref rise");
        go_to(501);
        check("R8", down_n, 1'b1, "down_n after fb rise");
        check("R8", up_n, 1'b1, "up_n after fb rise");
    endtask

    initial begin
        t_reset();
        t_divider();
        t_fb_leads();
        t_ref_leads();
        t_locked();
        t_rising();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule